// File: doc/BRIEF.md
# Clock Generator Configuration Register Slave (Two-Wire Serial)

This block is the serial configuration port of a clock generator. It watches a two-wire serial bus (clock and data), answers to one fixed 7-bit device address and gives a bus master read and write access to a bank of 8-bit configuration registers. Every register byte is also brought out on a flat parallel vector, so the clock-generation logic next to the block can use the settings directly. All registers come up with defaults at reset, so a system that never uses the bus still gets a working setup.

The first byte after the write address is a command code. When its top bit is set, the transfer touches one register, whose offset is given by the low seven bits. When its top bit is clear, the transfer is a block transfer that always begins at register 0 and steps upward. In a block write the master sends a byte count and then the data. In a block read the device first returns its register count and then the registers. Two register fields cannot be written: an identification byte and a nibble that holds strap pins captured during reset.

Bus lines are sampled by a two-flop synchronizer on a fast system clock. The device pulls SDA low through an open-drain style output. It changes SDA only while SCL is low.

Top module: `cfg_smbus_slave`

## Requirements
- R1: The device acknowledges only the address byte 0xD2 (write) or 0xD3 (read), that is 7-bit address 0x69. For any other address it leaves SDA released on the acknowledge bit, and the registers keep their values.
- R2: A write with a command code whose bit 7 is 1 stores the next data byte in the register at offset command[6:0]. The new value appears on `cfg_regs[8*offset +: 8]`. Further data bytes in the same transfer are acknowledged and discarded.
- R3: A byte read (command with bit 7 = 1, repeated start, address 0xD3) returns the register at offset command[6:0], MSB first.
- R4: A block write (command 0x00) takes a count byte N and writes the following data bytes to registers 0, 1, 2 and upward. Data bytes after the N-th are acknowledged and ignored. A stop after any complete byte keeps the bytes already written.
- R5: A block read (command 0x00, repeated start, address 0xD3) first returns the register count (16 with the default parameters, sent as 0x10) and then registers 0, 1, 2 and upward, until the master answers a byte with NACK.
- R6: After reset, register 4 holds 0x12, register 7 holds 0xFF, register 8 holds 0x0B, the low nibble of register 9 holds 0x8, register 6 holds the identification value (0x80 by default) and every other register holds 0x00.
- R7: Register 6 (identification) and bits 7:4 of register 9 (the `strap_in` value captured while reset is low) are read-only, and writes leave them unchanged. Bits 3:0 of register 9 stay writable.
- R8: Writes to offsets at or above the register count are acknowledged and discarded. Reads from those offsets return 0x00.
- R9: The device releases SDA while the master drives its acknowledge bit in a read and after a STOP. It only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset; also captures `strap_in` |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus |
| sda_drive_low | output | 1 | 1 = pull SDA low, 0 = release (open drain) |
| strap_in | input | 4 | Strap pin levels captured during reset |
| cfg_regs | output | NUM_REGS*8 | All register bytes, register k at bits 8k+7:8k |

## Verification
SDA is driven three system clocks after an SCL edge on the bus: two synchronizer stages and the output register. The bench leaves six system clocks between a bus edge and the next one, and it samples the acknowledge or data bit in the middle of the SCL high time, so each bit it sees is settled. A written byte shows on `cfg_regs` about four system clocks after the SCL fall that ends its eighth bit. The bench checks the parallel outputs only after the STOP, when every write has taken effect. Read-only and out-of-range cases are checked through byte reads and the parallel outputs right after the write that tried to change them.

// File: rtl/cfg_smbus_pkg.sv
// Shared types and reset defaults for the configuration register slave.
// Assumes: registers are 8 bits wide; defaults are indexed by offset.
package cfg_smbus_pkg;

    // Bus-level state of the link engine
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } link_state_t;

    // Meaning of the next byte received in a write transfer
    typedef enum logic [1:0] {
        PH_CMD,
        PH_COUNT,
        PH_DATA
    } rx_phase_t;

    // Reset value of each writable register
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            4:       return 8'h12;
            7:       return 8'hFF;
            8:       return 8'h0B;
            9:       return 8'h08;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes SCL/SDA into the system clock domain and flags bus events.
// Assumes: the system clock runs at least ~8x faster than SCL; both lines
// idle high, so the synchronizer resets to 1.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Synchronizer chains plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    // Event decode: START/STOP are SDA edges while SCL stays high
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/smb_link.sv
// Byte-level protocol engine: address match, command decode, byte/block
// write and read sequencing, acknowledge generation and data shift-out.
// Assumes: inputs come from smb_line_sync; rd_data is combinational on
// rd_addr; SDA is changed only on a detected SCL fall.
module smb_link
    import cfg_smbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic [7:0] rd_data,
    output logic [6:0] rd_addr,
    output logic       wr_en,
    output logic [6:0] wr_addr,
    output logic [7:0] wr_data,
    output logic       sda_drive_low,
    output logic       selected
);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

    link_state_t state;
    rx_phase_t   phase;
    logic [3:0]  bit_cnt;
    logic [7:0]  shreg;
    logic [6:0]  ptr;
    logic [7:0]  remain;
    logic        rw_read;
    logic        block_mode;
    logic        send_count;
    logic [7:0]  tx_byte;

    // Next byte to shift out: the count first in a block read, else data
    always_comb begin
        tx_byte = send_count ? COUNT_BYTE : rd_data;
        rd_addr = ptr;
    end

    // Protocol sequencer; START and STOP override any state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            phase         <= PH_CMD;
            bit_cnt       <= '0;
            shreg         <= '0;
            ptr           <= '0;
            remain        <= '0;
            rw_read       <= 1'b0;
            block_mode    <= 1'b0;
            send_count    <= 1'b0;
            wr_en         <= 1'b0;
            wr_addr       <= '0;
            wr_data       <= '0;
            sda_drive_low <= 1'b0;
            selected      <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_evt) begin
                state         <= ST_ADDR;
                bit_cnt       <= '0;
                sda_drive_low <= 1'b0;
                selected      <= 1'b0;
            end else if (stop_evt) begin
                state         <= ST_IDLE;
                sda_drive_low <= 1'b0;
                selected      <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (shreg[7:1] == DEV_ADDR) begin
                                state         <= ST_ADDR_ACK;
                                sda_drive_low <= 1'b1;
                                selected      <= 1'b1;
                                rw_read       <= shreg[0];
                                if (!shreg[0]) begin
                                    phase <= PH_CMD;
                                end else begin
                                    send_count <= block_mode;
                                    if (block_mode) ptr <= '0;
                                end
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_read) begin
                                state         <= ST_TX;
                                shreg         <= tx_byte;
                                sda_drive_low <= ~tx_byte[7];
                            end else begin
                                state         <= ST_RX;
                                sda_drive_low <= 1'b0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            state         <= ST_RX_ACK;
                            sda_drive_low <= 1'b1;
                            case (phase)
                                PH_CMD: begin
                                    block_mode <= ~shreg[7];
                                    ptr        <= shreg[7] ? shreg[6:0] : 7'd0;
                                    remain     <= 8'd1;
                                    phase      <= shreg[7] ? PH_DATA : PH_COUNT;
                                end
                                PH_COUNT: begin
                                    remain <= shreg;
                                    phase  <= PH_DATA;
                                end
                                default: begin
                                    if (remain != 8'd0) begin
                                        wr_en   <= 1'b1;
                                        wr_addr <= ptr;
                                        wr_data <= shreg;
                                        ptr     <= ptr + 7'd1;
                                        remain  <= remain - 8'd1;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            state         <= ST_RX;
                            bit_cnt       <= '0;
                            sda_drive_low <= 1'b0;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            state         <= ST_TX_ACK;
                            sda_drive_low <= 1'b0;
                            if (send_count) send_count <= 1'b0;
                            else            ptr <= ptr + 7'd1;
                        end else if (scl_fall && bit_cnt != 4'd0) begin
                            shreg         <= {shreg[6:0], 1'b0};
                            sda_drive_low <= ~shreg[6];
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise && sda_s) begin
                            state <= ST_IGNORE;
                        end else if (scl_fall) begin
                            state         <= ST_TX;
                            bit_cnt       <= '0;
                            shreg         <= tx_byte;
                            sda_drive_low <= ~tx_byte[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_regbank.sv
// Configuration register storage with reset defaults, one fixed
// identification byte and a strap nibble captured during reset.
// Assumes: one write per cycle; offsets >= NUM_REGS are dropped on write
// and read as zero.
module cfg_regbank
    import cfg_smbus_pkg::*;
#(
    parameter int         NUM_REGS     = 16,
    parameter int         ID_OFFSET    = 6,
    parameter int         STRAP_OFFSET = 9,
    parameter logic [7:0] ID_VALUE     = 8'h80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            strap_in,
    input  logic                  wr_en,
    input  logic [6:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [6:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int AW = $clog2(NUM_REGS);

    logic [7:0] regs [NUM_REGS];
    logic [3:0] strap_q;

    // Strap capture: follows the pins while reset is low, then holds
    always_ff @(posedge clk) begin
        if (!rst_n) strap_q <= strap_in;
    end

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        localparam logic [7:0] DEF = reg_default(gi);
        if (gi == ID_OFFSET) begin : g_id
            assign regs[gi] = ID_VALUE;
        end else if (gi == STRAP_OFFSET) begin : g_strap
            logic [3:0] lo_q;
            // Writable low nibble beside the read-only strap nibble
            always_ff @(posedge clk) begin
                if (!rst_n)                                lo_q <= DEF[3:0];
                else if (wr_en && wr_addr == 7'(gi))       lo_q <= wr_data[3:0];
            end
            assign regs[gi] = {strap_q, lo_q};
        end else begin : g_rw
            logic [7:0] q;
            // Plain read/write register
            always_ff @(posedge clk) begin
                if (!rst_n)                                q <= DEF;
                else if (wr_en && wr_addr == 7'(gi))       q <= wr_data;
            end
            assign regs[gi] = q;
        end
        assign cfg_regs[gi*8 +: 8] = regs[gi];
    end

    // Read mux with zero for unimplemented offsets
    always_comb begin
        if (rd_addr < 7'(NUM_REGS)) rd_data = regs[rd_addr[AW-1:0]];
        else                        rd_data = 8'h00;
    end

endmodule

// File: rtl/cfg_smbus_slave.sv
// Top: two-wire serial configuration slave for the clock generator.
// Connects the line synchronizer, the protocol engine and the register bank.
// Assumes: clk is much faster than SCL; SDA is wired open-drain outside.
module cfg_smbus_slave #(
    parameter logic [6:0] DEV_ADDR     = 7'h69,
    parameter int         NUM_REGS     = 16,
    parameter int         ID_OFFSET    = 6,
    parameter int         STRAP_OFFSET = 9,
    parameter logic [7:0] ID_VALUE     = 8'h80,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_drive_low,
    input  logic [3:0]            strap_in,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [6:0] rd_addr, wr_addr;
    logic [7:0] rd_data, wr_data;
    logic       wr_en, selected;

    smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    smb_link #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_link (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .sda_drive_low(sda_drive_low), .selected(selected)
    );

    cfg_regbank #(
        .NUM_REGS(NUM_REGS), .ID_OFFSET(ID_OFFSET),
        .STRAP_OFFSET(STRAP_OFFSET), .ID_VALUE(ID_VALUE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .cfg_regs(cfg_regs)
    );

endmodule

// File: rtl/cfg_smbus_checker.sv
// Protocol and register-integrity assertions for cfg_smbus_slave.
// Assumes: attached by the bind below; sees synchronized bus state.
module cfg_smbus_checker #(
    parameter int NUM_REGS     = 16,
    parameter int STRAP_OFFSET = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  stop_evt,
    input logic                  sda_drive_low,
    input logic                  selected,
    input logic                  wr_en,
    input logic [NUM_REGS*8-1:0] cfg_regs
);
    AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_drive_low); // R9

    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low) |-> !scl_s); // R9

    AST_DRIVE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drive_low |-> selected); // R1

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_regs[STRAP_OFFSET*8+4 +: 4])); // R7

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(cfg_regs)) |-> $past(wr_en)); // R2

endmodule

bind cfg_smbus_slave cfg_smbus_checker #(
    .NUM_REGS(NUM_REGS), .STRAP_OFFSET(STRAP_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
    .sda_drive_low(sda_drive_low), .selected(selected), .wr_en(wr_en),
    .cfg_regs(cfg_regs)
);

// File: tb/test_cfg_smbus_slave.sv
// Bench: bit-banged bus master, vector walk of byte write/read pairs, then
// directed tests for reset, addressing, block transfers and release rules.
module test_cfg_smbus_slave;
    localparam int NUM_REGS = 16;
    localparam int Q        = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] strap = 4'hA;
    logic sda_drive_low;
    logic [NUM_REGS*8-1:0] cfg_regs;
    logic sda_bus;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;
    assign sda_bus = sda_m & ~sda_drive_low;

    cfg_smbus_slave i_cfg_smbus_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus),
        .sda_drive_low(sda_drive_low), .strap_in(strap), .cfg_regs(cfg_regs)
    );

    // Vector: {offset[6:0], write data[7:0], expected read-back[7:0]}
    localparam logic [22:0] VEC [0:7] = '{
        {7'h00, 8'h5A, 8'h5A},
        {7'h03, 8'hC3, 8'hC3},
        {7'h0F, 8'hFF, 8'hFF},
        {7'h06, 8'h11, 8'h80},
        {7'h09, 8'h37, 8'hA7},
        {7'h20, 8'h99, 8'h00},
        {7'h7F, 8'h12, 8'h00},
        {7'h04, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        ack = sda_bus;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(input logic nack, output logic [7:0] b, output logic slv_drive);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0;
        end
        wq(); sda_m = nack; wq(); scl_m = 1'b1; wq();
        slv_drive = sda_drive_low;
        wq(); scl_m = 1'b0;
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d);
        logic a;
        bus_start();
        put_byte(8'hD2, a);
        put_byte({1'b1, off}, a);
        put_byte(d, a);
        chk("R8 data byte acknowledged", 32'(a), 32'd0);
        bus_stop();
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
        logic a, drv;
        bus_start();
        put_byte(8'hD2, a);
        put_byte({1'b1, off}, a);
        bus_start();
        put_byte(8'hD3, a);
        get_byte(1'b1, d, drv);
        bus_stop();
    endtask

    initial begin
        logic [7:0] rd;
        logic a, drv;
        string tag;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6 reset defaults
        chk("R6 reg4 default",  32'(cfg_regs[4*8 +: 8]), 32'h12);
        chk("R6 reg7 default",  32'(cfg_regs[7*8 +: 8]), 32'hFF);
        chk("R6 reg8 default",  32'(cfg_regs[8*8 +: 8]), 32'h0B);
        chk("R6 reg0 default",  32'(cfg_regs[0 +: 8]),   32'h00);
        chk("R6 R7 id byte",    32'(cfg_regs[6*8 +: 8]), 32'h80);
        chk("R6 R7 strap+low",  32'(cfg_regs[9*8 +: 8]), 32'hA8);
        chk("R9 idle release",  32'(sda_drive_low),      32'd0);

        // R1 foreign address: no acknowledge, no change
        bus_start();
        put_byte(8'hA0, a);
        chk("R1 foreign addr nack", 32'(a), 32'd1);
        put_byte(8'h84, a);
        put_byte(8'h55, a);
        bus_stop();
        chk("R1 foreign addr no write", 32'(cfg_regs[4*8 +: 8]), 32'h12);

        // R1 own address acknowledged
        bus_start();
        put_byte(8'hD2, a);
        chk("R1 own addr ack", 32'(a), 32'd0);
        bus_stop();

        // Vector walk: byte write then byte read (R2 R3 R7 R8)
        for (int i = 0; i < 8; i++) begin
            logic [6:0] off;
            off = VEC[i][22:16];
            byte_write(off, VEC[i][15:8]);
            byte_read(off, rd);
            if (off == 7'h06 || off == 7'h09) tag = "R7 read-only field";
            else if (off >= 7'(NUM_REGS))    tag = "R8 out-of-range";
            else                             tag = "R2 R3 byte write/read";
            chk(tag, 32'(rd), 32'(VEC[i][7:0]));
            if (off < 7'(NUM_REGS))
                chk({tag, " port"}, 32'(cfg_regs[off*8 +: 8]), 32'(VEC[i][7:0]));
        end

        // R2 extra bytes in a byte write are discarded
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h81, a); put_byte(8'h66, a); put_byte(8'h77, a);
        bus_stop();
        chk("R2 byte write extra", 32'(cfg_regs[8 +: 16]), 32'h0066);

        // R4 block write, count 3, fourth byte ignored
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h03, a);
        put_byte(8'h11, a); put_byte(8'h22, a); put_byte(8'h33, a); put_byte(8'h44, a);
        chk("R4 beyond count acked", 32'(a), 32'd0);
        bus_stop();
        chk("R4 block data", 32'(cfg_regs[0 +: 32]), 32'hC3332211);

        // R4 early stop keeps bytes already written
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a); put_byte(8'h05, a); put_byte(8'h55, a);
        bus_stop();
        chk("R4 early stop", 32'(cfg_regs[0 +: 16]), 32'h2255);

        // R5 block read: count then ascending data; R9 master-ack release
        bus_start();
        put_byte(8'hD2, a); put_byte(8'h00, a);
        bus_start();
        put_byte(8'hD3, a);
        get_byte(1'b0, rd, drv);
        chk("R5 count byte", 32'(rd), 32'h10);
        chk("R9 release in master ack", 32'(drv), 32'd0);
        get_byte(1'b0, rd, drv); chk("R5 reg0", 32'(rd), 32'h55);
        get_byte(1'b0, rd, drv); chk("R5 reg1", 32'(rd), 32'h22);
        get_byte(1'b0, rd, drv); chk("R5 reg2", 32'(rd), 32'h33);
        get_byte(1'b1, rd, drv); chk("R5 reg3", 32'(rd), 32'hC3);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R9 released after stop", 32'(sda_drive_low), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule